// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steers a simple instruction-fetch pipeline into and out of an interrupt service routine. One clock edge marks one instruction cycle. A peripheral raises a one-cycle request and says which half of the instruction cycle it arrived in. The sequencer raises an interrupt flag and lets the instruction in progress finish. It then runs a fixed four-cycle entry. The entry saves the fetch address and status byte as one frame on an internal stack, reads the vector table, loads the program counter with the service routine address and injects bubbles at set cycles.

When the decoder reports a return-from-interrupt instruction, the sequencer runs a matching four-cycle return. It pops the newest frame, reloads the program counter and status byte, and spends one bubble while the fetch at the restored address completes. The interrupted code then resumes. A request that arrives while a sequence runs is held and served once the sequencer is idle again. Pushing onto a full stack, or returning with an empty one, sets a sticky error flag.

Top module: `irqs_seq`

## Requirements
- R1: `irq_flag_o` rises in the instruction cycle after the one in which `irq_req_i` is high. It stays high until the first entry cycle, and `busy_o` is low while it is high.
- R2: For a request with `irq_late_i`=0 (first half), the first entry cycle is the second cycle after the request cycle. For `irq_late_i`=1 (second half), it is the third cycle after the request cycle.
- R3: Entry cycle 1 asserts `busy_o` and `stk_push_o` and pushes the frame {`pc_i`, `sr_i`} presented in that cycle. This is the address of the next instruction not yet executed. There is no NOP and no PC load in this cycle.
- R4: Entry cycle 2 asserts only `busy_o` and `nop_o`.
- R5: Entry cycle 3 asserts `vec_rd_o`, drives `vec_addr_o` to VEC_ADDR, and asserts `pc_load_o` with `pc_val_o` = VEC_ADDR. The vector table returns data in the following cycle.
- R6: Entry cycle 4 asserts `pc_load_o` with `pc_val_o` = `vec_data_i` and asserts `nop_o`. The sequencer is idle in the next cycle.
- R7: A `ret_i` pulse in an idle cycle starts the return. Cycles 1 and 2 assert `stk_pop_o`. Cycle 2 also asserts `pc_load_o` and `sr_load_o`, carrying the newest frame on `pc_val_o` and `sr_val_o`. Cycle 3 asserts only `busy_o` and `nop_o`. Cycle 4 asserts only `busy_o`. The sequencer is idle after cycle 4.
- R8: Frames come back last-in first-out, up to STK_DEPTH frames.
- R9: An entry with STK_DEPTH frames already stored keeps `stk_push_o` low in cycle 1 and sets `err_o`. A `ret_i` with an empty stack sets `err_o` and starts no sequence. `err_o` stays high until reset.
- R10: `irq_req_i` seen while a wait, entry or return is in progress is held pending. The sequencer raises `irq_flag_o` in the cycle after it is next idle and uses first-half timing. `ret_i` outside an idle cycle is ignored. If `ret_i` and a request meet in an idle cycle, the return runs and the request is held pending.
- R11: After reset every output is low and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Peripheral interrupt request, one cycle |
| irq_late_i | input | 1 | Request arrived in the second half of the cycle |
| ret_i | input | 1 | Return-from-interrupt decoded |
| pc_i | input | PC_W | Current fetch address |
| sr_i | input | SR_W | Current low status byte |
| vec_data_i | input | PC_W | Vector table read data, one cycle after read |
| irq_flag_o | output | 1 | Interrupt flag, waiting to enter |
| busy_o | output | 1 | Entry or return cycle in progress |
| nop_o | output | 1 | Inject a NOP this cycle |
| pc_load_o | output | 1 | Load program counter |
| pc_val_o | output | PC_W | Value to load into the program counter |
| sr_load_o | output | 1 | Load status byte |
| sr_val_o | output | SR_W | Status value to load |
| vec_rd_o | output | 1 | Vector table read strobe |
| vec_addr_o | output | PC_W | Vector table address |
| stk_push_o | output | 1 | Frame pushed this cycle |
| stk_pop_o | output | 1 | Return pop cycle |
| err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
The flag is due one edge after the request. The first entry cycle is due two edges after a first-half request and three after a second-half one. Each later entry or return cycle follows exactly one edge after the one before it, and vector data counts as valid one edge after the read. The bench drives inputs and samples outputs two nanoseconds after each rising edge, so each check reads the state the design reached at that edge. A table of per-cycle input and expected-output vectors covers both latencies, a pending request and an ignored return. Directed runs then compare the loaded addresses and restored frames, including the overflow and underflow cases.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int PC_W = 16;
    localparam int SR_W = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_WAIT2, S_WAIT1,
        S_ENT1, S_ENT2, S_ENT3, S_ENT4,
        S_RET1, S_RET2, S_RET3, S_RET4
    } st_t;

    typedef enum logic [1:0] { PSEL_NONE, PSEL_VEC, PSEL_ISR, PSEL_RET } psel_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [SR_W-1:0] sr;
    } frame_t;

    typedef struct packed {
        logic  flag;
        logic  busy;
        logic  push;
        logic  pop;
        logic  nop;
        logic  pcld;
        logic  vecrd;
        logic  srld;
        psel_t psel;
    } ctl_t;

    // fixed successor for every state other than idle
    function automatic st_t seq_next(st_t s);
        case (s)
            S_WAIT2: return S_WAIT1;
            S_WAIT1: return S_ENT1;
            S_ENT1:  return S_ENT2;
            S_ENT2:  return S_ENT3;
            S_ENT3:  return S_ENT4;
            S_RET1:  return S_RET2;
            S_RET2:  return S_RET3;
            S_RET3:  return S_RET4;
            default: return S_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/irqs_req_gate.sv
module irqs_req_gate (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic late_i,
    input  logic idle_i,
    input  logic ret_i,
    output logic take_o,
    output logic late_o
);
    logic pend_q;
    logic want;

    assign want   = req_i | pend_q;
    assign take_o = idle_i & ~ret_i & want;
    // a held request always uses first-half timing
    assign late_o = late_i & ~pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= want & ~take_o;
    end
endmodule

// File: rtl/irqs_frame_stack.sv
module irqs_frame_stack
    import irqs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  logic   pop_i,
    input  frame_t frame_i,
    output frame_t top_o,
    output logic   empty_o,
    output logic   full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t           mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_c;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign top_c   = cnt_q - CNT_W'(1);
    assign top_o   = empty_o ? '0 : mem[IDX_W'(top_c)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push_i && !full_o) begin
            mem[IDX_W'(cnt_q)] <= frame_i;
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop_i && !empty_o) begin
            cnt_q <= top_c;
        end
    end
endmodule

// File: rtl/irqs_ctl_decode.sv
module irqs_ctl_decode
    import irqs_pkg::*;
(
    input  st_t  st_i,
    input  logic full_i,
    output ctl_t ctl_o
);
    always_comb begin
        ctl_o = '0;
        unique case (st_i)
            S_WAIT2, S_WAIT1: ctl_o.flag = 1'b1;
            S_ENT1: begin
                ctl_o.busy = 1'b1;
                ctl_o.push = ~full_i;
            end
            S_ENT2: begin
                ctl_o.busy = 1'b1;
                ctl_o.nop  = 1'b1;
            end
            S_ENT3: begin
                ctl_o.busy  = 1'b1;
                ctl_o.vecrd = 1'b1;
                ctl_o.pcld  = 1'b1;
                ctl_o.psel  = PSEL_VEC;
            end
            S_ENT4: begin
                ctl_o.busy = 1'b1;
                ctl_o.pcld = 1'b1;
                ctl_o.nop  = 1'b1;
                ctl_o.psel = PSEL_ISR;
            end
            S_RET1: begin
                ctl_o.busy = 1'b1;
                ctl_o.pop  = 1'b1;
            end
            S_RET2: begin
                ctl_o.busy = 1'b1;
                ctl_o.pop  = 1'b1;
                ctl_o.pcld = 1'b1;
                ctl_o.srld = 1'b1;
                ctl_o.psel = PSEL_RET;
            end
            S_RET3: begin
                ctl_o.busy = 1'b1;
                ctl_o.nop  = 1'b1;
            end
            S_RET4:  ctl_o.busy = 1'b1;
            default: ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/irqs_seq.sv
module irqs_seq
    import irqs_pkg::*;
#(
    parameter int              STK_DEPTH = 4,
    parameter logic [PC_W-1:0] VEC_ADDR  = 16'h0008
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req_i,
    input  logic            irq_late_i,
    input  logic            ret_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [SR_W-1:0] sr_i,
    input  logic [PC_W-1:0] vec_data_i,
    output logic            irq_flag_o,
    output logic            busy_o,
    output logic            nop_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_val_o,
    output logic            sr_load_o,
    output logic [SR_W-1:0] sr_val_o,
    output logic            vec_rd_o,
    output logic [PC_W-1:0] vec_addr_o,
    output logic            stk_push_o,
    output logic            stk_pop_o,
    output logic            err_o
);
    st_t    st_q, st_d;
    ctl_t   ctl;
    frame_t top;
    logic   idle, take, late, empty, full, err_q;

    assign idle = (st_q == S_IDLE);

    irqs_req_gate u_gate (
        .clk(clk), .rst(rst), .req_i(irq_req_i), .late_i(irq_late_i),
        .idle_i(idle), .ret_i(ret_i), .take_o(take), .late_o(late)
    );

    irqs_frame_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push_i(ctl.push), .pop_i(st_q == S_RET2),
        .frame_i('{pc: pc_i, sr: sr_i}),
        .top_o(top), .empty_o(empty), .full_o(full)
    );

    irqs_ctl_decode u_dec (.st_i(st_q), .full_i(full), .ctl_o(ctl));

    always_comb begin
        st_d = seq_next(st_q);
        if (idle) begin
            if (ret_i)     st_d = empty ? S_IDLE : S_RET1;
            else if (take) st_d = late ? S_WAIT2 : S_WAIT1;
            else           st_d = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_q | ((st_q == S_ENT1) & full) | (idle & ret_i & empty);
        end
    end

    always_comb begin
        case (ctl.psel)
            PSEL_VEC: pc_val_o = VEC_ADDR;
            PSEL_ISR: pc_val_o = vec_data_i;
            PSEL_RET: pc_val_o = top.pc;
            default:  pc_val_o = '0;
        endcase
    end

    assign irq_flag_o = ctl.flag;
    assign busy_o     = ctl.busy;
    assign nop_o      = ctl.nop;
    assign pc_load_o  = ctl.pcld;
    assign sr_load_o  = ctl.srld;
    assign sr_val_o   = ctl.srld ? top.sr : '0;
    assign vec_rd_o   = ctl.vecrd;
    assign vec_addr_o = ctl.vecrd ? VEC_ADDR : '0;
    assign stk_push_o = ctl.push;
    assign stk_pop_o  = ctl.pop;
    assign err_o      = err_q;
endmodule

// File: rtl/irqs_seq_chk.sv
module irqs_seq_chk
    import irqs_pkg::*;
#(
    parameter logic [PC_W-1:0] VEC_ADDR = 16'h0008
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_flag_o,
    input logic            busy_o,
    input logic            nop_o,
    input logic            pc_load_o,
    input logic [PC_W-1:0] pc_val_o,
    input logic            sr_load_o,
    input logic            vec_rd_o,
    input logic [PC_W-1:0] vec_addr_o,
    input logic            stk_push_o,
    input logic            stk_pop_o,
    input logic            err_o
);
    // R1
    flag_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        irq_flag_o |-> !busy_o);
    // R4
    push_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
        stk_push_o |=> nop_o && !pc_load_o && busy_o);
    // R5
    vec_addr_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_o |-> pc_load_o && pc_val_o == VEC_ADDR && vec_addr_o == VEC_ADDR);
    // R6
    isr_load_chk: assert property (@(posedge clk) disable iff (rst)
        vec_rd_o |=> pc_load_o && nop_o && !vec_rd_o);
    // R7
    restore_pop_chk: assert property (@(posedge clk) disable iff (rst)
        sr_load_o |-> stk_pop_o && pc_load_o && $past(stk_pop_o));
    // R7
    restore_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
        sr_load_o |=> nop_o && !stk_pop_o);
    // R3
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stk_push_o, stk_pop_o}));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind irqs_seq irqs_seq_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
    .clk(clk), .rst(rst), .irq_flag_o(irq_flag_o), .busy_o(busy_o),
    .nop_o(nop_o), .pc_load_o(pc_load_o), .pc_val_o(pc_val_o),
    .sr_load_o(sr_load_o), .vec_rd_o(vec_rd_o), .vec_addr_o(vec_addr_o),
    .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o), .err_o(err_o)
);

// File: tb/sim_irqs_seq.sv
`timescale 1ns/1ps
module sim_irqs_seq;
    import irqs_pkg::*;

    localparam logic [PC_W-1:0] VEC = 16'h0008;
    localparam logic [PC_W-1:0] ISR = 16'h2000;
    localparam int DEPTH = 4;
    localparam int ROWS  = 35;

    // row = {req, late, ret, flag, busy, push, pop, nop, pcld, vecrd, srld}
    localparam logic [10:0] VECS [ROWS] = '{
        {3'b100, 8'b1000_0000}, {3'b000, 8'b0110_0000}, {3'b000, 8'b0100_1000},
        {3'b000, 8'b0100_0110}, {3'b000, 8'b0100_1100}, {3'b000, 8'b0000_0000},
        {3'b001, 8'b0101_0000}, {3'b000, 8'b0101_0101}, {3'b000, 8'b0100_1000},
        {3'b000, 8'b0100_0000}, {3'b000, 8'b0000_0000},
        {3'b110, 8'b1000_0000}, {3'b000, 8'b1000_0000}, {3'b000, 8'b0110_0000},
        {3'b100, 8'b0100_1000}, {3'b001, 8'b0100_0110}, {3'b000, 8'b0100_1100},
        {3'b000, 8'b0000_0000}, {3'b000, 8'b1000_0000}, {3'b000, 8'b0110_0000},
        {3'b000, 8'b0100_1000}, {3'b000, 8'b0100_0110}, {3'b000, 8'b0100_1100},
        {3'b000, 8'b0000_0000},
        {3'b001, 8'b0101_0000}, {3'b000, 8'b0101_0101}, {3'b000, 8'b0100_1000},
        {3'b000, 8'b0100_0000}, {3'b000, 8'b0000_0000},
        {3'b001, 8'b0101_0000}, {3'b000, 8'b0101_0101}, {3'b000, 8'b0100_1000},
        {3'b000, 8'b0100_0000}, {3'b000, 8'b0000_0000},
        {3'b001, 8'b0000_0000}
    };

    logic            clk = 1'b0, rst = 1'b1;
    logic            req = 1'b0, late = 1'b0, ret = 1'b0;
    logic [PC_W-1:0] pc = '0, vdata = '0;
    logic [SR_W-1:0] sr = '0;
    logic            flag, busy, nop, pcld, srld, vecrd, push, pop, err;
    logic [PC_W-1:0] pcv, vaddr;
    logic [SR_W-1:0] srv;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqs_seq #(.STK_DEPTH(DEPTH), .VEC_ADDR(VEC)) u0 (
        .clk(clk), .rst(rst), .irq_req_i(req), .irq_late_i(late), .ret_i(ret),
        .pc_i(pc), .sr_i(sr), .vec_data_i(vdata), .irq_flag_o(flag),
        .busy_o(busy), .nop_o(nop), .pc_load_o(pcld), .pc_val_o(pcv),
        .sr_load_o(srld), .sr_val_o(srv), .vec_rd_o(vecrd), .vec_addr_o(vaddr),
        .stk_push_o(push), .stk_pop_o(pop), .err_o(err)
    );

    // vector table model: data one cycle after the read strobe
    always @(posedge clk) if (vecrd) vdata <= ISR;

    function automatic logic [7:0] outs();
        return {flag, busy, push, pop, nop, pcld, vecrd, srld};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1; req = 0; late = 0; ret = 0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic run_irq(input logic lt, input logic [PC_W-1:0] p,
                           input logic [SR_W-1:0] s, input logic exp_push);
        pc = p; sr = s; req = 1'b1; late = lt;
        step();
        req = 1'b0; late = 1'b0;
        chk("R1 flag after request", 32'(flag), 32'(1));
        if (lt) begin
            step();
            chk("R2 late wait", 32'(flag & ~busy), 32'(1));
        end
        step();
        chk("R3 push in entry 1", 32'({busy, push, nop, pcld}), 32'({1'b1, exp_push, 2'b00}));
        step();
        chk("R4 entry 2", 32'(outs()), 32'(8'b0100_1000));
        step();
        chk("R5 vector load", 32'({vecrd, pcld, pcv, vaddr}), 32'({2'b11, VEC, VEC}));
        step();
        chk("R6 isr load", 32'({pcld, nop, pcv}), 32'({2'b11, ISR}));
        step();
        chk("R6 idle after entry", 32'(outs()), 32'(0));
    endtask

    task automatic run_ret(input logic [PC_W-1:0] p, input logic [SR_W-1:0] s);
        ret = 1'b1;
        step();
        ret = 1'b0;
        chk("R7 return 1", 32'(outs()), 32'(8'b0101_0000));
        step();
        chk("R8 restored frame", 32'({pcld, srld, pcv, srv}), 32'({2'b11, p, s}));
        step();
        chk("R7 return 3", 32'(outs()), 32'(8'b0100_1000));
        step();
        chk("R7 return 4", 32'(outs()), 32'(8'b0100_0000));
        step();
    endtask

    initial begin
        do_reset();
        chk("R11 reset outputs", 32'({outs(), err, pcv}), 32'(0));

        pc = 16'h0100; sr = 8'h33;
        for (int i = 0; i < ROWS; i++) begin
            {req, late, ret} = VECS[i][10:8];
            step();
            chk($sformatf("R2 R4 R5 R6 R7 R10 row %0d", i), 32'(outs()), 32'(VECS[i][7:0]));
        end
        ret = 1'b0;
        chk("R9 underflow err", 32'(err), 32'(1));
        step();
        chk("R9 err sticky", 32'({err, busy}), 32'(2'b10));

        do_reset();
        chk("R11 err cleared", 32'(err), 32'(0));
        run_irq(1'b0, 16'h0102, 8'h5A, 1'b1);
        run_irq(1'b1, 16'h0204, 8'hA5, 1'b1);
        run_ret(16'h0204, 8'hA5);
        run_ret(16'h0102, 8'h5A);
        chk("R9 no err on balanced", 32'(err), 32'(0));

        do_reset();
        for (int k = 1; k <= DEPTH; k++)
            run_irq(1'b0, PC_W'(16'h10 * k), SR_W'(k), 1'b1);
        chk("R9 no err at full", 32'(err), 32'(0));
        run_irq(1'b0, 16'h0F00, 8'hFF, 1'b0);
        chk("R9 overflow err", 32'(err), 32'(1));
        for (int k = DEPTH; k >= 1; k--)
            run_ret(PC_W'(16'h10 * k), SR_W'(k));

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule